// File: doc/BRIEF.md
# Multi-sample test pattern generator

This block drives a wide parallel word built from several N-bit samples. Downstream serial link logic uses it as a known stimulus. On each clock cycle with the enable input high, the block delivers one new word. The pattern keeps running across words: the lowest sample of each new word follows from the highest sample of the word before it.

Two patterns are available. In the checkerboard pattern, neighbouring samples are bitwise inverses of each other. In the ramp pattern, each sample is one above the sample below it. A synchronous reset loads the seed into the lowest sample and captures the pattern select, and the rest of the word is built from the seed by the chosen pattern. The bus width is the product of the frame clock divider, the converter count, the samples per converter per frame and the sample width.

Top module: `pattern_gen`

## Requirements
- R1: The width of `data_o` equals FRAME_DIV × CONVERTERS × SAMPLES_PER_CONV × SAMPLE_W. Sample k occupies bits [k*SAMPLE_W +: SAMPLE_W], and sample 0 is the lowest.
- R2: On a clock edge with `rst_i` high, sample 0 of `data_o` loads `seed_i` and the pattern select is captured from `mode_i`. The other samples are derived by the rules of that pattern. Reset takes priority over `en_i`.
- R3: With the checkerboard pattern captured (`mode_i`=0 at reset), every sample k>0 is the bitwise inverse of sample k-1 of the same word.
- R4: In the checkerboard pattern, each enabled edge makes sample 0 of the new word the bitwise inverse of the highest sample of the previous word.
- R5: With the ramp pattern captured (`mode_i`=1 at reset), every sample k>0 equals sample k-1 of the same word plus one.
- R6: In the ramp pattern, each enabled edge makes sample 0 of the new word the highest sample of the previous word plus one.
- R7: Ramp increments wrap modulo 2^SAMPLE_W, both inside a word and across words, and raise no overflow indication.
- R8: On an edge with `en_i` low and `rst_i` low, `data_o` keeps its value and the sequence does not advance.
- R9: A change on `mode_i` while `rst_i` is low does not affect the output. The new pattern applies only after the next reset, which also reloads the seed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset; loads the seed and captures the pattern select |
| en_i | input | 1 | Advance to the next word on this edge |
| mode_i | input | 1 | Pattern select sampled at reset: 0 checkerboard, 1 ramp |
| seed_i | input | SAMPLE_W | Starting value of sample 0 |
| data_o | output | FRAME_DIV*CONVERTERS*SAMPLES_PER_CONV*SAMPLE_W | Registered parallel test word |

## Verification
The bench uses an odd sample count, so the checkerboard visibly alternates between words. A design that restarted each word from the seed, or that took the next word from the lowest sample instead of the highest, would then show the wrong phase after one or three steps. The ramp is seeded near the top of its range, so the increment must wrap both inside a word and across words. A design that carried into a neighbouring sample would corrupt the byte above. The bench also holds enable low across several edges and changes the mode select without a reset. A design that drifted while disabled, or that let the live mode input steer an active run, would show a moved word or a swapped pattern.

// File: rtl/pattern_gen_pkg.sv
package pattern_gen_pkg;
  typedef enum logic {
    PAT_CHECKER = 1'b0,
    PAT_RAMP    = 1'b1
  } pat_mode_e;
endpackage

// File: rtl/pattern_step.sv
module pattern_step
  import pattern_gen_pkg::*;
#(
  parameter int SAMPLE_W = 8
) (
  input  pat_mode_e             mode,
  input  logic [SAMPLE_W-1:0]   d,
  output logic [SAMPLE_W-1:0]   q
);
  localparam logic [SAMPLE_W-1:0] ONE = SAMPLE_W'(1);

  always_comb begin
    if (mode == PAT_RAMP) q = d + ONE;
    else                  q = ~d;
  end
endmodule

// File: rtl/pattern_word_build.sv
module pattern_word_build
  import pattern_gen_pkg::*;
#(
  parameter int SAMPLE_W    = 8,
  parameter int NUM_SAMPLES = 3,
  localparam int DATA_W     = SAMPLE_W * NUM_SAMPLES
) (
  input  pat_mode_e             mode,
  input  logic [SAMPLE_W-1:0]   base,
  output logic [DATA_W-1:0]     word
);
  logic [SAMPLE_W-1:0] chain [NUM_SAMPLES];

  assign chain[0] = base;

  for (genvar k = 1; k < NUM_SAMPLES; k++) begin : g_link
    pattern_step #(.SAMPLE_W(SAMPLE_W)) i_step (
      .mode (mode),
      .d    (chain[k-1]),
      .q    (chain[k])
    );
  end

  for (genvar k = 0; k < NUM_SAMPLES; k++) begin : g_pack
    assign word[k*SAMPLE_W +: SAMPLE_W] = chain[k];
  end
endmodule

// File: rtl/pattern_gen.sv
module pattern_gen
  import pattern_gen_pkg::*;
#(
  parameter int SAMPLE_W         = 8,
  parameter int FRAME_DIV        = 1,
  parameter int CONVERTERS       = 1,
  parameter int SAMPLES_PER_CONV = 3,
  localparam int NUM_SAMPLES     = FRAME_DIV * CONVERTERS * SAMPLES_PER_CONV,
  localparam int DATA_W          = NUM_SAMPLES * SAMPLE_W
) (
  input  logic                clk_i,
  input  logic                rst_i,
  input  logic                en_i,
  input  logic                mode_i,
  input  logic [SAMPLE_W-1:0] seed_i,
  output logic [DATA_W-1:0]   data_o
);
  pat_mode_e           mode_q;
  pat_mode_e           mode_sel;
  logic [SAMPLE_W-1:0] top_smp;
  logic [SAMPLE_W-1:0] top_next;
  logic [SAMPLE_W-1:0] base_next;
  logic [DATA_W-1:0]   word_next;

  // Highest sample of the current word seeds the next word.
  assign top_smp = data_o[DATA_W-1 -: SAMPLE_W];

  pattern_step #(.SAMPLE_W(SAMPLE_W)) i_wrap_step (
    .mode (mode_q),
    .d    (top_smp),
    .q    (top_next)
  );

  assign mode_sel  = rst_i ? pat_mode_e'(mode_i) : mode_q;
  assign base_next = rst_i ? seed_i : top_next;

  pattern_word_build #(
    .SAMPLE_W    (SAMPLE_W),
    .NUM_SAMPLES (NUM_SAMPLES)
  ) i_build (
    .mode (mode_sel),
    .base (base_next),
    .word (word_next)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      mode_q <= pat_mode_e'(mode_i);
      data_o <= word_next;
    end else if (en_i) begin
      data_o <= word_next;
    end
  end
endmodule

// File: rtl/pattern_gen_checker.sv
module pattern_gen_checker
  import pattern_gen_pkg::*;
#(
  parameter int SAMPLE_W    = 8,
  parameter int NUM_SAMPLES = 3,
  localparam int DATA_W     = SAMPLE_W * NUM_SAMPLES
) (
  input logic              clk_i,
  input logic              rst_i,
  input logic              en_i,
  input pat_mode_e         mode_q,
  input logic [DATA_W-1:0] data_o
);
  localparam logic [SAMPLE_W-1:0] ONE = SAMPLE_W'(1);

  logic [SAMPLE_W-1:0] smp [NUM_SAMPLES];

  for (genvar k = 0; k < NUM_SAMPLES; k++) begin : g_unpack
    assign smp[k] = data_o[k*SAMPLE_W +: SAMPLE_W];
  end

  for (genvar k = 1; k < NUM_SAMPLES; k++) begin : g_intra
    // R3
    checker_intra_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (mode_q == PAT_CHECKER) |-> (smp[k] == ~smp[k-1]));
    // R5 R7
    ramp_intra_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (mode_q == PAT_RAMP) |-> (smp[k] == SAMPLE_W'(smp[k-1] + ONE)));
  end

  // R4
  checker_cross_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (!rst_i && en_i && mode_q == PAT_CHECKER) |=> (smp[0] == ~$past(smp[NUM_SAMPLES-1])));

  // R6 R7
  ramp_cross_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (!rst_i && en_i && mode_q == PAT_RAMP) |=>
      (smp[0] == SAMPLE_W'($past(smp[NUM_SAMPLES-1]) + ONE)));

  // R8
  hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (!rst_i && !en_i) |=> $stable(data_o));

  // R9
  mode_keep_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !rst_i |=> $stable(mode_q));
endmodule

bind pattern_gen pattern_gen_checker #(
  .SAMPLE_W    (SAMPLE_W),
  .NUM_SAMPLES (NUM_SAMPLES)
) i_pattern_gen_checker (
  .clk_i  (clk_i),
  .rst_i  (rst_i),
  .en_i   (en_i),
  .mode_q (mode_q),
  .data_o (data_o)
);

// File: tb/test_pattern_gen.sv
`timescale 1ns/1ps
module test_pattern_gen;
  logic        clk_i = 1'b0;
  logic        rst_i = 1'b1;
  logic        en_i = 1'b0;
  logic        mode_i = 1'b0;
  logic [7:0]  seed_i = 8'h00;
  logic [23:0] data_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  pattern_gen i_pattern_gen (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .en_i   (en_i),
    .mode_i (mode_i),
    .seed_i (seed_i),
    .data_o (data_o)
  );

  typedef struct packed {
    logic        mode;
    logic [7:0]  seed;
    logic [3:0]  steps;
    logic [3:0]  req;
    logic [23:0] exp;
  } vec_t;

  // mode 0 checkerboard, 1 ramp; sample 0 in bits [7:0]
  localparam vec_t VECS [12] = '{
    '{1'b0, 8'h5A, 4'd0, 4'd3, 24'h5AA55A},  // R2 R3 reset word
    '{1'b0, 8'h5A, 4'd1, 4'd4, 24'hA55AA5},  // R4 one step
    '{1'b0, 8'h5A, 4'd2, 4'd4, 24'h5AA55A},  // R4 two steps
    '{1'b0, 8'h00, 4'd0, 4'd3, 24'h00FF00},  // R3
    '{1'b0, 8'h00, 4'd3, 4'd4, 24'hFF00FF},  // R4 odd steps
    '{1'b1, 8'h10, 4'd0, 4'd5, 24'h121110},  // R5
    '{1'b1, 8'h10, 4'd1, 4'd6, 24'h151413},  // R6
    '{1'b1, 8'h10, 4'd3, 4'd6, 24'h1B1A19},  // R6
    '{1'b1, 8'hFD, 4'd0, 4'd5, 24'hFFFEFD},  // R5
    '{1'b1, 8'hFD, 4'd1, 4'd7, 24'h020100},  // R7 wrap across words
    '{1'b1, 8'hFE, 4'd0, 4'd7, 24'h00FFFE},  // R7 wrap inside word
    '{1'b1, 8'h3C, 4'd2, 4'd6, 24'h444342}   // R6
  };

  task automatic check(input string tag, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: data_o=%h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic m, input logic [7:0] s, input logic e);
    @(negedge clk_i);
    rst_i = 1'b1; mode_i = m; seed_i = s; en_i = e;
    @(negedge clk_i);
    rst_i = 1'b0; en_i = 1'b0;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      en_i = 1'b1;
    end
    @(negedge clk_i);
    en_i = 1'b0;
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete");
      report();
    end
  end

  initial begin
    repeat (2) @(negedge clk_i);

    // R1 width of the bus
    checks++;
    if ($bits(data_o) != 24) begin
      errors++;
      $display("FAIL R1: width=%0d expected 24", $bits(data_o));
    end

    foreach (VECS[i]) begin
      do_reset(VECS[i].mode, VECS[i].seed, 1'b0);
      run(int'(VECS[i].steps));
      check($sformatf("R%0d vector %0d", VECS[i].req, i), data_o, VECS[i].exp);
    end

    // R8 hold while disabled
    do_reset(1'b1, 8'h10, 1'b0);
    repeat (4) @(negedge clk_i);
    check("R8 hold after reset", data_o, 24'h121110);
    run(1);
    repeat (2) @(negedge clk_i);
    check("R8 hold after step", data_o, 24'h151413);

    // R9 mode change without reset is ignored
    mode_i = 1'b0;
    run(1);
    check("R9 ramp continues", data_o, 24'h181716);
    do_reset(1'b0, 8'h10, 1'b0);
    check("R9 new mode after reset", data_o, 24'h10EF10);

    // R2 reset wins over enable
    do_reset(1'b1, 8'h77, 1'b1);
    check("R2 reset priority", data_o, 24'h797877);
    do_reset(1'b0, 8'hC3, 1'b0);
    check("R2 reset mid-run", data_o, 24'hC33CC3);

    done = 1'b1;
    report();
  end
endmodule